// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the target-side engine that lets a device announce an event on a shared, open-drain alert wire and then identify itself when a bus controller polls the alert response address. It watches already-synchronized SCL and SDA samples, decodes START, STOP and the first byte of each transfer, and decides whether to claim the poll. When it claims it, the block sends its own 7-bit address back to the controller. It competes bit by bit with any other device that answers the same poll.

Several such devices may hold the alert wire low at once. Each poll serves exactly one of them: the one with the lowest address wins the wired-AND contest on SDA and releases its alert. The others back off and keep their alert asserted, so the controller polls again until the alert wire goes high. Both outputs are pull-down enables for external open-drain pads. Neither output ever drives a line high.

Top module: `smba_responder`

## Requirements
- R1: After reset, `sda_pull` and `alert_pull` are both 0.
- R2: A rising edge on `alert_req` sets `alert_pull` to 1 by the second clock edge after it is seen. Once set, `alert_pull` is cleared only by a won reply or by reset.
- R3: A first byte of 0x19 (address 0001100, R/W bit = 1 in bit 0) is acknowledged with SDA low during the ninth SCL pulse. This happens only when `alert_en` is 1 and `alert_pull` is 1.
- R4: No acknowledge is given, and `alert_pull` is unchanged, in any of these cases: the first byte is 0x18 (write), any other address is sent, `alert_en` is 0, or no alert is pending.
- R5: After the acknowledge, the reply byte is `dev_addr` MSB first in bits 7..1, with bit 0 equal to 0.
- R6: During the reply, if the block releases SDA to send a 1 but samples 0 on the SCL rising edge, it has lost arbitration. It then drives nothing until the next START, and `alert_pull` stays 1.
- R7: A device that sends all 8 reply bits without losing keeps `alert_pull` at 1 through the eighth bit. It clears `alert_pull` on the rising edge of the ninth SCL pulse, which is the controller's acknowledge slot.
- R8: If the controller drives an ACK (SDA = 0) in that ninth slot, the block sends further bytes of all ones (SDA released) until it sees a NACK.
- R9: A START or STOP at any point returns the block to waiting for a new first byte. A device that lost arbitration answers the next poll and returns its own address.
- R10: `sda_pull` changes only on a clock edge at which SCL was sampled low. Data is sampled on the SCL rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level (wired-AND bus value) |
| alert_req | input | 1 | Event request; a rising edge raises the alert |
| alert_en | input | 1 | 1 lets the block answer alert response polls |
| dev_addr | input | 7 | Static 7-bit address of this device |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| alert_pull | output | 1 | 1 pulls the shared alert wire low, 0 releases it |

## Verification
The block's state reaches the ports through two channels: the reply byte the controller reads, and the alert pull-down. A bad bit count or shift-register load shows up as a corrupted reply byte within the eight reply clocks of the same transfer. A missed arbitration loss shows up as a byte that mixes two addresses at the first bit where they differ. A wrong decision on when to release the alert shows at `alert_pull` within three system clocks of the ninth SCL rising edge. It also shows one poll later, as a second device that never gets served. The two-device bus makes these errors visible, because a correct loser is silent on SDA and keeps its alert asserted after the STOP.

// File: rtl/smba_pkg.sv
package smba_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [ADDR_W-1:0] POLL_ADDR = 7'b0001100;
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } rsp_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic is_poll_read(input logic [BYTE_W-1:0] b);
        return b == {POLL_ADDR, 1'b1};
    endfunction

endpackage

// File: rtl/smba_bus_monitor.sv
module smba_bus_monitor
    import smba_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        evt.rise  = scl & ~scl_q;
        evt.fall  = ~scl & scl_q;
        evt.start = scl & scl_q & sda_q & ~sda;
        evt.stop  = scl & scl_q & ~sda_q & sda;
        evt.sda   = sda;
    end

endmodule

// File: rtl/smba_alert_ctrl.sv
module smba_alert_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic alert_req,
    input  logic clear_won,
    output logic alert_active
);

    logic req_q;
    logic req_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q        <= 1'b0;
            req_prev     <= 1'b0;
            alert_active <= 1'b0;
        end else begin
            req_q    <= alert_req;
            req_prev <= req_q;
            if (req_q && !req_prev)
                alert_active <= 1'b1;
            else if (clear_won)
                alert_active <= 1'b0;
        end
    end

    // R2
    req_sets_alert_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |=> alert_active);

    // R7
    alert_drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(alert_active) |-> $past(clear_won));

endmodule

// File: rtl/smba_reply_fsm.sv
module smba_reply_fsm
    import smba_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              alert_en,
    input  logic              alert_active,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              sda_pull,
    output logic              clear_won
);

    rsp_state_e        st;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              lost;
    logic              first_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            sh         <= '0;
            cnt        <= '0;
            sda_pull   <= 1'b0;
            lost       <= 1'b0;
            first_byte <= 1'b0;
            clear_won  <= 1'b0;
        end else begin
            clear_won <= 1'b0;
            if (evt.start) begin
                st       <= ST_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
                lost     <= 1'b0;
            end else if (evt.stop) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (evt.rise && cnt != LAST_BIT) begin
                            sh  <= {sh[BYTE_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (evt.fall && cnt == LAST_BIT) begin
                            if (is_poll_read(sh) && alert_en && alert_active) begin
                                st       <= ST_ACK;
                                sda_pull <= 1'b1;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.fall) begin
                            st         <= ST_TX;
                            sh         <= {dev_addr, 1'b0};
                            cnt        <= '0;
                            first_byte <= 1'b1;
                            sda_pull   <= ~dev_addr[ADDR_W-1];
                        end
                    end
                    ST_TX: begin
                        if (evt.rise) begin
                            if (sh[BYTE_W-1] && !evt.sda) begin
                                lost     <= 1'b1;
                                sda_pull <= 1'b0;
                                st       <= ST_SKIP;
                            end else begin
                                sh  <= {sh[BYTE_W-2:0], 1'b1};
                                cnt <= cnt + 1'b1;
                            end
                        end else if (evt.fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_pull <= 1'b0;
                                st       <= ST_MACK;
                            end else begin
                                sda_pull <= ~sh[BYTE_W-1];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.rise) begin
                            clear_won  <= first_byte;
                            first_byte <= 1'b0;
                            if (evt.sda) begin
                                st <= ST_SKIP;
                            end else begin
                                st  <= ST_TX;
                                sh  <= '1;
                                cnt <= '0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6
    lost_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        lost |-> !sda_pull);

    // R3
    reply_needs_alert_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TX && first_byte) |-> alert_active);

endmodule

// File: rtl/smba_responder.sv
module smba_responder
    import smba_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              alert_req,
    input  logic              alert_en,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              sda_pull,
    output logic              alert_pull
);

    bus_evt_t evt;
    logic     clear_won;

    smba_bus_monitor u_mon (
        .clk (clk),
        .rst (rst),
        .scl (scl_in),
        .sda (sda_in),
        .evt (evt)
    );

    smba_alert_ctrl u_alert (
        .clk          (clk),
        .rst          (rst),
        .alert_req    (alert_req),
        .clear_won    (clear_won),
        .alert_active (alert_pull)
    );

    smba_reply_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .alert_en     (alert_en),
        .alert_active (alert_pull),
        .dev_addr     (dev_addr),
        .sda_pull     (sda_pull),
        .clear_won    (clear_won)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_pull && !alert_pull));

    // R10
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !$past(scl_in));

endmodule

// File: tb/smba_responder_tb.sv
module smba_responder_tb;

    localparam int HALF = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic       m_scl, m_sda;
    logic       req_a, req_b, en_a, en_b;
    logic       pull_a, pull_b, alert_a, alert_b;
    logic       bus_sda;
    logic [6:0] addr_a = 7'h52;
    logic [6:0] addr_b = 7'h56;

    assign bus_sda = m_sda & ~pull_a & ~pull_b;

    smba_responder u_dut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(bus_sda),
        .alert_req(req_a), .alert_en(en_a), .dev_addr(addr_a),
        .sda_pull(pull_a), .alert_pull(alert_a)
    );

    smba_responder u_peer (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(bus_sda),
        .alert_req(req_b), .alert_en(en_b), .dev_addr(addr_b),
        .sda_pull(pull_b), .alert_pull(alert_b)
    );

    typedef struct {
        string      tag;
        logic [7:0] val;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] act_q[$];
    int         total = 0;
    int         bad   = 0;
    bit         done  = 1'b0;

    task automatic expect_val(input string tag, input logic [7:0] v);
        item_t it;
        it.tag = tag;
        it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic observe(input logic [7:0] v);
        act_q.push_back(v);
    endtask

    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t      e;
            logic [7:0] a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            total++;
            if (a !== e.val) begin
                bad++;
                $display("FAIL %s: got %h expected %h", e.tag, a, e.val);
            end
        end
    end

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_h();
        m_scl = 1'b1; wait_h();
        m_sda = 1'b0; wait_h();
        m_scl = 1'b0; @(negedge clk);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_h();
        m_scl = 1'b1; wait_h();
        m_sda = 1'b1; wait_h();
    endtask

    task automatic bit_out(input logic b);
        m_sda = b;    wait_h();
        m_scl = 1'b1; wait_h();
        m_scl = 1'b0; @(negedge clk);
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; wait_h();
        m_scl = 1'b1;
        repeat (HALF / 2) @(negedge clk);
        b = bus_sda;
        repeat (HALF / 2) @(negedge clk);
        m_scl = 1'b0; @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(ack);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
    endtask

    task automatic pulse_req(input bit which_a, input bit which_b);
        req_a = which_a; req_b = which_b;
        repeat (3) @(negedge clk);
        req_a = 1'b0; req_b = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic       ack;
        logic [7:0] b;
        m_scl = 1'b1; m_sda = 1'b1; rst = 1'b1;
        req_a = 1'b0; req_b = 1'b0; en_a = 1'b1; en_b = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state of all pull-downs
        expect_val("R1", 8'h00);
        observe({4'h0, pull_a, pull_b, alert_a, alert_b});

        // R4: poll with no alert pending gets no acknowledge
        expect_val("R4", 8'h01);
        bus_start(); write_byte(8'h19, ack); observe({7'h0, ack}); bus_stop();

        // R2: request raises alert within two edges, only for A
        req_a = 1'b1;
        repeat (3) @(negedge clk);
        expect_val("R2", 8'h02);
        observe({6'h0, alert_a, alert_b});
        req_a = 1'b0;
        @(negedge clk);

        // R4: write form of the poll address is not acknowledged
        expect_val("R4", 8'h01);
        expect_val("R4", 8'h01);
        bus_start(); write_byte(8'h18, ack); observe({7'h0, ack}); bus_stop();
        observe({7'h0, alert_a});

        // R4: disabled device ignores the poll
        en_a = 1'b0;
        expect_val("R4", 8'h01);
        bus_start(); write_byte(8'h19, ack); observe({7'h0, ack}); bus_stop();
        en_a = 1'b1;

        // R4: other address read is not acknowledged
        expect_val("R4", 8'h01);
        bus_start(); write_byte(8'h31, ack); observe({7'h0, ack}); bus_stop();

        // R3 R5 R7: single responder
        expect_val("R3", 8'h00);
        expect_val("R5", 8'hA4);
        expect_val("R7", 8'h01);
        expect_val("R7", 8'h00);
        bus_start(); write_byte(8'h19, ack); observe({7'h0, ack});
        read_byte(b); observe(b);
        observe({7'h0, alert_a});
        bit_out(1'b1);
        observe({7'h0, alert_a});
        bus_stop();

        // R6: two responders, lower address wins
        pulse_req(1'b1, 1'b1);
        expect_val("R2", 8'h03);
        observe({6'h0, alert_a, alert_b});
        expect_val("R3", 8'h00);
        expect_val("R6", 8'hA4);
        expect_val("R6", 8'h01);
        bus_start(); write_byte(8'h19, ack); observe({7'h0, ack});
        read_byte(b); observe(b);
        bit_out(1'b1); bus_stop();
        observe({6'h0, alert_a, alert_b});

        // R9: second poll serves the former loser
        expect_val("R9", 8'h00);
        expect_val("R9", 8'hAC);
        expect_val("R9", 8'h00);
        bus_start(); write_byte(8'h19, ack); observe({7'h0, ack});
        read_byte(b); observe(b);
        bit_out(1'b1); bus_stop();
        observe({6'h0, alert_a, alert_b});

        // R8: controller ACK leads to bytes of all ones
        pulse_req(1'b1, 1'b0);
        expect_val("R8", 8'hA4);
        expect_val("R8", 8'hFF);
        expect_val("R8", 8'hFF);
        expect_val("R8", 8'h00);
        bus_start(); write_byte(8'h19, ack);
        read_byte(b); observe(b);
        bit_out(1'b0);
        read_byte(b); observe(b);
        bit_out(1'b0);
        read_byte(b); observe(b);
        bit_out(1'b1); bus_stop();
        observe({7'h0, alert_a});

        // R9: repeated START mid-reply restarts decoding
        pulse_req(1'b1, 1'b0);
        expect_val("R9", 8'h00);
        expect_val("R9", 8'hA4);
        expect_val("R9", 8'h00);
        bus_start(); write_byte(8'h19, ack);
        bit_in(ack); bit_in(ack);
        bus_start(); write_byte(8'h19, ack); observe({7'h0, ack});
        read_byte(b); observe(b);
        bit_out(1'b1); bus_stop();
        observe({7'h0, alert_a});

        repeat (4) @(negedge clk);
        while (exp_q.size() > 0 && act_q.size() == 0) begin
            item_t e;
            e = exp_q.pop_front();
            total++;
            bad++;
            $display("FAIL %s: got none expected %h", e.tag, e.val);
        end
        finish_run();
    end

endmodule